// File: doc/BRIEF.md
# Multi-level page table walker

This block runs after a miss in the address translation cache. It takes a logical address and a 3-bit function code. It then follows a tree of translation tables held in memory, reading one descriptor per level through a physical read port that bypasses translation. The walk ends in one of two ways. If it finds a page descriptor, it writes a translation cache entry and then strobes a retry of the original access. Otherwise it reports a fault. In both cases a done strobe carries a status code and the number of descriptors read.

Configuration inputs control the walk:
- The width in bits of the index field for each of four logical-address levels, called A, B, C and D. Level A takes the most significant bits, and each following level takes the bits just below the previous one.
- A flag that adds an extra first level indexed by the function code.
- A flag that enables the supervisor root pointer.
- Two 64-bit root pointers.

The type code in each pointer sets the size of the descriptors in the table it points to, and therefore the scale applied to the index. A bus lock is held from the first descriptor read until the walk ends.

Pointer and descriptor formats:
- Type codes are 0 = invalid, 1 = page, 2 = table of 4-byte descriptors and 3 = table of 8-byte descriptors.
- A 4-byte descriptor is a single word. Its bits [1:0] hold the type and its bits [31:4] hold the address.
- An 8-byte descriptor is two words read from `addr` and then `addr+4`. The first word holds the type in bits [1:0] and an upper index limit in bits [31:16]. The second word holds the address in bits [31:4].
- A root pointer has the layout of an 8-byte descriptor. The first word sits in bits [63:32] and the second word in bits [31:0].

Top module: `xlat_walker`

## Requirements
- R1: The supervisor root pointer is used only when `fc_i[2]` is 1 and `srp_en_i` is 1. Every other combination uses the CPU root pointer.
- R2: When `fc_index_en_i` is 1, the first table is indexed by the function code and the next level by field A. When the flag is 0, the first table is indexed by field A and the next level by field B.
- R3: A descriptor is read at address base + (index << 2) when the parent's type is 2. It is read at base + (index << 3), as two reads at that address and that address + 4, when the parent's type is 3.
- R4: The address field of a table descriptor becomes the base of the next table. Levels continue with fields B, C and D in that order. A table descriptor read at field D ends the walk with status 1.
- R5: A descriptor with type 0 ends the walk at once with status 1, and `levels_o` equals the number of descriptors read.
- R6: An index that exceeds the limit of an 8-byte parent (the root pointer, or an 8-byte table descriptor) ends the walk with status 2 before the read is issued. 4-byte parents carry no limit.
- R7: A page descriptor causes one `ent_wr_o` pulse. The pulse carries the logical address, the function code, and the data {word0, word1} (word1 is 0 for a 4-byte page). In the next cycle `retry_o` and `done_o` pulse together with status 0.
- R8: `lock_o` is high whenever a memory request is valid. Once it rises, it stays high until the cycle in which `done_o` pulses, and then it falls.
- R9: A selected root pointer whose type is 0 or 1 ends the walk with status 1 and 0 levels. No memory read is made and the lock is not raised.
- R10: A start request made while a walk is in progress is ignored, and that walk completes unchanged.
- R11: After reset no request, lock, cache write, retry or done is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| la_i | input | 32 | Logical address that missed |
| fc_i | input | 3 | Function code of the access |
| fc_index_en_i | input | 1 | Add a first level indexed by the function code |
| srp_en_i | input | 1 | Enable the supervisor root pointer |
| width_a_i | input | 4 | Index width of field A |
| width_b_i | input | 4 | Index width of field B |
| width_c_i | input | 4 | Index width of field C |
| width_d_i | input | 4 | Index width of field D |
| crp_i | input | 64 | CPU root pointer |
| srp_i | input | 64 | Supervisor root pointer |
| mem_req_valid_o | output | 1 | Physical read request valid |
| mem_req_addr_o | output | 32 | Physical read address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| lock_o | output | 1 | Bus lock held across the walk |
| ent_wr_o | output | 1 | Translation cache write strobe |
| ent_tag_o | output | 32 | Logical address of the entry |
| ent_fc_o | output | 3 | Function code of the entry |
| ent_data_o | output | 64 | Page descriptor words {word0, word1} |
| retry_o | output | 1 | Retry strobe for the original access |
| done_o | output | 1 | Walk finished |
| status_o | output | 2 | 0 = success, 1 = invalid, 2 = limit violation |
| levels_o | output | 3 | Descriptors read during the walk |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- A tree that mixes 4-byte and 8-byte tables. A design that scales the index by the wrong descriptor size, or issues only one read for an 8-byte descriptor, would read the wrong address or return the wrong page data and read count.
- Walks that index by function code. A design that fails to shift the field order when the function-code level is on would land on the wrong descriptor.
- A limit violation at the root and at a deeper level. A design that checks the limit after the read instead of before it would show an extra read.
- A table descriptor found at the last field, which must fault.
- A root pointer with an invalid type, which must fault without any read or lock.
- A second start request pulsed in the middle of a walk, which a careless design would take as a new walk.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

  typedef enum logic [1:0] {
    DT_INVALID = 2'd0,
    DT_PAGE    = 2'd1,
    DT_SHORT   = 2'd2,
    DT_LONG    = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    WS_OK      = 2'd0,
    WS_INVALID = 2'd1,
    WS_LIMIT   = 2'd2
  } wstat_e;

  // field selector values: 0 = function code, 1..4 = logical fields A..D
  localparam logic [2:0] SEL_FC = 3'd0;
  localparam logic [2:0] SEL_A  = 3'd1;
  localparam logic [2:0] SEL_D  = 3'd4;

  // w-bit field of la starting off bits below the MSB
  function automatic logic [31:0] la_field(input logic [31:0] la,
                                           input logic [6:0]  off,
                                           input logic [4:0]  w);
    logic [31:0] t;
    if (w == 5'd0 || off > 7'd31) return 32'd0;
    t = la << off;
    return t >> (6'd32 - {1'b0, w});
  endfunction

  // address of the descriptor to fetch
  function automatic logic [31:0] desc_addr(input logic [31:0] base,
                                            input logic [31:0] idx,
                                            input logic        long8);
    return base + (long8 ? (idx << 3) : (idx << 2));
  endfunction

endpackage

// File: rtl/xw_root_sel.sv
module xw_root_sel #(
  parameter int RP_W = 64
) (
  input  logic [2:0]      fc_i,
  input  logic            srp_en_i,
  input  logic [RP_W-1:0] crp_i,
  input  logic [RP_W-1:0] srp_i,
  output logic [RP_W-1:0] root_o,
  output logic            use_srp_o
);
  assign use_srp_o = fc_i[2] & srp_en_i;
  assign root_o    = use_srp_o ? srp_i : crp_i;

  always_comb begin
    if (!fc_i[2]) p_crp_user_r1: assert (root_o == crp_i);
  end
endmodule

// File: rtl/xw_index_gen.sv
module xw_index_gen #(
  parameter int AW   = 32,
  parameter int FW   = 4,
  parameter int NFLD = 4
) (
  input  logic [AW-1:0]        la_i,
  input  logic [2:0]           fc_i,
  input  logic [2:0]           sel_i,
  input  logic [NFLD*FW-1:0]   widths_i,
  output logic [AW-1:0]        idx_o
);
  import xlat_walker_pkg::*;

  localparam int OW = 7;

  logic [OW-1:0] off [NFLD+1];
  logic [AW-1:0] fld [NFLD];

  assign off[0] = '0;
  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    logic [FW-1:0] w;
    assign w          = widths_i[g*FW +: FW];
    assign off[g+1]   = off[g] + OW'(w);
    assign fld[g]     = la_field(la_i, off[g], 5'(w));
  end

  always_comb begin
    idx_o = '0;
    if (sel_i == SEL_FC) idx_o = AW'(fc_i);
    else if (sel_i <= SEL_D) idx_o = fld[sel_i - SEL_A];
  end
endmodule

// File: rtl/xw_fetch.sv
module xw_fetch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic          long_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          req_ready_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic [DW-1:0] w0_o,
  output logic [DW-1:0] w1_o
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  fst_e          st_q;
  logic [AW-1:0] addr_q;
  logic          long_q, beat_q;
  logic [DW-1:0] first_q;

  assign req_valid_o = (st_q == F_REQ);
  assign req_addr_o  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= F_IDLE; addr_q <= '0; long_q <= 1'b0; beat_q <= 1'b0;
      first_q <= '0; done_o <= 1'b0; w0_o <= '0; w1_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        F_IDLE: if (go_i) begin
          addr_q <= addr_i; long_q <= long_i; beat_q <= 1'b0; st_q <= F_REQ;
        end
        F_REQ: if (req_ready_i) st_q <= F_WAIT;
        default: if (rvalid_i) begin
          if (long_q && !beat_q) begin
            first_q <= rdata_i; beat_q <= 1'b1;
            addr_q  <= addr_q + STEP; st_q <= F_REQ;
          end else begin
            done_o <= 1'b1;
            w0_o   <= long_q ? first_q : rdata_i;
            w1_o   <= long_q ? rdata_i : '0;
            st_q   <= F_IDLE;
          end
        end
      endcase
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int FW    = 4,
  parameter int LIM_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] la_i,
  input  logic [2:0]    fc_i,
  input  logic          fc_index_en_i,
  input  logic          srp_en_i,
  input  logic [FW-1:0] width_a_i,
  input  logic [FW-1:0] width_b_i,
  input  logic [FW-1:0] width_c_i,
  input  logic [FW-1:0] width_d_i,
  input  logic [2*DW-1:0] crp_i,
  input  logic [2*DW-1:0] srp_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          lock_o,
  output logic          ent_wr_o,
  output logic [AW-1:0] ent_tag_o,
  output logic [2:0]    ent_fc_o,
  output logic [2*DW-1:0] ent_data_o,
  output logic          retry_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic [2:0]    levels_o
);
  import xlat_walker_pkg::*;

  localparam int RP_W = 2 * DW;
  localparam int NFLD = 4;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FETCH, S_RETRY} wst_e;

  wst_e            st_q;
  logic [AW-1:0]   la_q, base_q;
  logic [2:0]      fc_q, sel_q, lvl_q;
  logic [LIM_W-1:0] lim_q;
  logic            has_lim_q, long_next_q, locked_q;

  logic [RP_W-1:0] root;
  logic            use_srp;
  logic [AW-1:0]   idx, f_addr;
  logic            f_done;
  logic [DW-1:0]   f_w0, f_w1;
  dtype_e          root_type, f_type;

  // named events
  logic lim_hit, fetch_go, got_page, got_table, got_fault, walk_end;

  xw_root_sel #(.RP_W(RP_W)) u_root (
    .fc_i(fc_i), .srp_en_i(srp_en_i), .crp_i(crp_i), .srp_i(srp_i),
    .root_o(root), .use_srp_o(use_srp));

  xw_index_gen #(.AW(AW), .FW(FW), .NFLD(NFLD)) u_idx (
    .la_i(la_q), .fc_i(fc_q), .sel_i(sel_q),
    .widths_i({width_d_i, width_c_i, width_b_i, width_a_i}), .idx_o(idx));

  xw_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go_i(fetch_go), .addr_i(f_addr),
    .long_i(long_next_q), .req_valid_o(mem_req_valid_o),
    .req_addr_o(mem_req_addr_o), .req_ready_i(mem_req_ready_i),
    .rvalid_i(mem_rvalid_i), .rdata_i(mem_rdata_i),
    .done_o(f_done), .w0_o(f_w0), .w1_o(f_w1));

  assign root_type = dtype_e'(root[DW+1:DW]);
  assign f_type    = dtype_e'(f_w0[1:0]);
  assign lim_hit   = (st_q == S_CHECK) && has_lim_q && (idx > AW'(lim_q));
  assign fetch_go  = (st_q == S_CHECK) && !lim_hit;
  assign f_addr    = desc_addr(base_q, idx, long_next_q);
  assign got_page  = (st_q == S_FETCH) && f_done && (f_type == DT_PAGE);
  assign got_table = (st_q == S_FETCH) && f_done && f_type[1] && (sel_q != SEL_D);
  assign got_fault = (st_q == S_FETCH) && f_done && !got_page && !got_table;
  assign walk_end  = lim_hit || got_fault || (st_q == S_RETRY);
  assign lock_o    = mem_req_valid_o | locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; la_q <= '0; base_q <= '0; fc_q <= '0; sel_q <= '0;
      lvl_q <= '0; lim_q <= '0; has_lim_q <= 1'b0; long_next_q <= 1'b0;
      ent_wr_o <= 1'b0; ent_tag_o <= '0; ent_fc_o <= '0; ent_data_o <= '0;
      retry_o <= 1'b0; done_o <= 1'b0; status_o <= '0; levels_o <= '0;
    end else begin
      ent_wr_o <= 1'b0; retry_o <= 1'b0; done_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          la_q        <= la_i;
          fc_q        <= fc_i;
          base_q      <= {root[AW-1:4], 4'b0};
          lim_q       <= root[RP_W-1 -: LIM_W];
          has_lim_q   <= 1'b1;
          long_next_q <= (root_type == DT_LONG);
          sel_q       <= fc_index_en_i ? SEL_FC : SEL_A;
          lvl_q       <= '0;
          if (!root_type[1]) begin
            done_o <= 1'b1; status_o <= WS_INVALID; levels_o <= '0;
          end else st_q <= S_CHECK;
        end
        S_CHECK: begin
          if (lim_hit) begin
            done_o <= 1'b1; status_o <= WS_LIMIT; levels_o <= lvl_q;
            st_q <= S_IDLE;
          end else st_q <= S_FETCH;
        end
        S_FETCH: if (f_done) begin
          lvl_q <= lvl_q + 3'd1;
          if (got_page) begin
            ent_wr_o   <= 1'b1;
            ent_tag_o  <= la_q;
            ent_fc_o   <= fc_q;
            ent_data_o <= {f_w0, f_w1};
            levels_o   <= lvl_q + 3'd1;
            st_q       <= S_RETRY;
          end else if (got_table) begin
            base_q      <= long_next_q ? {f_w1[AW-1:4], 4'b0} : {f_w0[AW-1:4], 4'b0};
            lim_q       <= f_w0[DW-1 -: LIM_W];
            has_lim_q   <= long_next_q;
            long_next_q <= (f_type == DT_LONG);
            sel_q       <= sel_q + 3'd1;
            st_q        <= S_CHECK;
          end else begin
            done_o <= 1'b1; status_o <= WS_INVALID; levels_o <= lvl_q + 3'd1;
            st_q <= S_IDLE;
          end
        end
        default: begin
          retry_o <= 1'b1; done_o <= 1'b1; status_o <= WS_OK; st_q <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) locked_q <= 1'b0;
    else if (mem_req_valid_o) locked_q <= 1'b1;
    else if (walk_end) locked_q <= 1'b0;
  end

  p_lock_covers_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> lock_o);
  p_lock_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> done_o);
  p_retry_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr_o |=> retry_o && done_o && status_o == 2'd0);
  p_no_fetch_on_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lim_hit |=> !mem_req_valid_o);
  p_levels_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> levels_o <= 3'd5 && status_o != 2'd3);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_IDLE && !$past(fetch_go) |-> !mem_req_valid_o);
  p_supervisor_root_r1: assert property (@(posedge clk) disable iff (!rst_n)
    use_srp |-> fc_i[2]);
endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  typedef struct packed {
    logic        fcl;
    logic        sre;
    logic [2:0]  fc;
    logic [31:0] la;
    logic [1:0]  st;
    logic [2:0]  lv;
    logic [3:0]  rd;
    logic [63:0] data;
  } vec_t;

  localparam int NV = 16;
  // R1 R2 R3 R4 R5 R6 R7 exercised across the table
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,3'd1,32'h0100_0000,2'd0,3'd2,4'd3,64'h00000001_ABCDE000}, // R3 long page
    '{1'b0,1'b0,3'd1,32'h0200_0000,2'd0,3'd3,4'd4,64'h12345001_00000000}, // R4
    '{1'b0,1'b0,3'd1,32'h0210_0000,2'd1,3'd3,4'd4,64'h0},                 // R5
    '{1'b0,1'b0,3'd1,32'h0250_0000,2'd2,3'd2,4'd3,64'h0},                 // R6 deep
    '{1'b0,1'b0,3'd1,32'h0000_0000,2'd1,3'd2,4'd3,64'h0},                 // R5 long invalid
    '{1'b0,1'b0,3'd1,32'h1000_0000,2'd0,3'd1,4'd1,64'h55550001_00000000}, // R7
    '{1'b0,1'b0,3'd1,32'h2001_0000,2'd0,3'd4,4'd4,64'h77770001_00000000}, // R4 four levels
    '{1'b0,1'b0,3'd1,32'h2000_0000,2'd1,3'd4,4'd4,64'h0},                 // R4 table at D
    '{1'b1,1'b0,3'd1,32'h0000_0000,2'd0,3'd1,4'd1,64'h55550001_00000000}, // R2
    '{1'b1,1'b0,3'd2,32'h0010_0000,2'd0,3'd4,4'd4,64'h77770001_00000000}, // R2 shift
    '{1'b1,1'b1,3'd5,32'h0000_0000,2'd0,3'd1,4'd2,64'h00000001_0BADF000}, // R1 srp
    '{1'b1,1'b1,3'd6,32'h0000_0000,2'd1,3'd1,4'd2,64'h0},                 // R1 R5
    '{1'b0,1'b1,3'd5,32'h9000_0000,2'd2,3'd0,4'd0,64'h0},                 // R6 root
    '{1'b0,1'b1,3'd5,32'h3000_0000,2'd0,3'd1,4'd2,64'h00000001_33333000}, // R1
    '{1'b1,1'b0,3'd5,32'h0000_0000,2'd1,3'd1,4'd1,64'h0},                 // R1 sre off
    '{1'b1,1'b1,3'd1,32'h0000_0000,2'd0,3'd1,4'd1,64'h55550001_00000000}  // R1 fc2 low
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] la = '0;
  logic [2:0]  fc = '0;
  logic fcl = 1'b0, sre = 1'b0;
  logic [63:0] crp = {32'h000F_0002, 32'h0000_0100};
  logic [63:0] srp = {32'h0007_0003, 32'h0000_0200};
  logic req_valid, ready = 1'b0, rvalid = 1'b0, lock, ent_wr, retry, done;
  logic [31:0] req_addr, rdata = '0, ent_tag;
  logic [2:0]  ent_fc, levels;
  logic [63:0] ent_data;
  logic [1:0]  status;

  always #2.5 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .la_i(la), .fc_i(fc),
    .fc_index_en_i(fcl), .srp_en_i(sre), .width_a_i(4'd4), .width_b_i(4'd4),
    .width_c_i(4'd4), .width_d_i(4'd4), .crp_i(crp), .srp_i(srp),
    .mem_req_valid_o(req_valid), .mem_req_addr_o(req_addr),
    .mem_req_ready_i(ready), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .lock_o(lock), .ent_wr_o(ent_wr), .ent_tag_o(ent_tag), .ent_fc_o(ent_fc),
    .ent_data_o(ent_data), .retry_o(retry), .done_o(done),
    .status_o(status), .levels_o(levels));

  logic [31:0] mem [256];
  logic        hs = 1'b0;
  logic [31:0] hs_addr = '0;
  logic [7:0]  lfsr = 8'hA5;
  int reads = 0, lock_err = 0, lock_seen = 0, cyc = 0;
  logic lock_prev = 1'b0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    hs <= req_valid & ready;
    hs_addr <= req_addr;
    if (req_valid & ready) reads <= reads + 1;
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    rvalid <= hs;
    rdata  <= mem[hs_addr[9:2]];
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready  <= lfsr[0] | lfsr[2];
    if (req_valid && !lock) lock_err <= lock_err + 1;
    if (lock_prev && !lock && !done) lock_err <= lock_err + 1;
    if (lock) lock_seen <= 1;
    lock_prev <= lock;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [63:0] got_data;
  logic [31:0] got_tag;
  logic [2:0]  got_fc;
  int          wr_cnt;
  logic        got_retry;

  task automatic walk(input logic f, input logic s, input logic [2:0] c,
                      input logic [31:0] a, input bit ghost);
    int t;
    @(negedge clk);
    fcl = f; sre = s; fc = c; la = a; start = 1'b1;
    reads = 0; lock_err = 0; lock_seen = 0; wr_cnt = 0;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 500) begin
      if (ent_wr) begin got_data = ent_data; got_tag = ent_tag; got_fc = ent_fc; wr_cnt++; end
      if (ghost && t == 3) begin start = 1'b1; la = 32'h1000_0000; end
      else start = 1'b0;
      @(negedge clk); t++;
    end
    start = 1'b0;
    got_retry = retry;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem['h100>>2] = 32'h0000_0183; mem['h104>>2] = 32'h5555_0001;
    mem['h108>>2] = 32'h0000_0342;
    mem['h188>>2] = 32'h0000_0001; mem['h18C>>2] = 32'hABCD_E000;
    mem['h190>>2] = 32'h0001_0002; mem['h194>>2] = 32'h0000_0300;
    mem['h300>>2] = 32'h1234_5001;
    mem['h340>>2] = 32'h0000_0382; mem['h380>>2] = 32'h0000_03C2;
    mem['h3C0>>2] = 32'h0000_0102; mem['h3C4>>2] = 32'h7777_0001;
    mem['h218>>2] = 32'h0000_0001; mem['h21C>>2] = 32'h3333_3000;
    mem['h228>>2] = 32'h0000_0001; mem['h22C>>2] = 32'h0BAD_F000;

    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!req_valid && !lock && !ent_wr && !retry && !done, "R11 reset outputs",
        {59'd0, req_valid, lock, ent_wr, retry, done}, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      walk(VEC[v].fcl, VEC[v].sre, VEC[v].fc, VEC[v].la, 1'b0);
      chk(done && status == VEC[v].st, $sformatf("R5/R6 v%0d status", v), 64'(status), 64'(VEC[v].st));
      chk(levels == VEC[v].lv, $sformatf("R4 v%0d levels", v), 64'(levels), 64'(VEC[v].lv));
      chk(reads == VEC[v].rd, $sformatf("R3 v%0d reads", v), 64'(reads), 64'(VEC[v].rd));
      chk(lock_err == 0 && (VEC[v].rd == 0 || lock_seen == 1), $sformatf("R8 v%0d lock", v),
          64'(lock_err), 64'd0);
      if (VEC[v].st == 2'd0) begin
        chk(wr_cnt == 1 && got_data == VEC[v].data, $sformatf("R7 v%0d entry", v), got_data, VEC[v].data);
        chk(got_tag == VEC[v].la && got_fc == VEC[v].fc && got_retry, $sformatf("R7 v%0d tag", v),
            {got_tag, 29'd0, got_fc}, {VEC[v].la, 29'd0, VEC[v].fc});
      end else
        chk(wr_cnt == 0 && !got_retry, $sformatf("R7 v%0d no write", v), 64'(wr_cnt), 64'd0);
      @(negedge clk);
      chk(!lock, $sformatf("R8 v%0d lock after done", v), 64'(lock), 64'd0);
    end

    // R9 root pointer with invalid type
    crp = {32'h000F_0000, 32'h0000_0100};
    walk(1'b0, 1'b0, 3'd1, 32'h1000_0000, 1'b0);
    chk(status == 2'd1 && levels == 3'd0, "R9 root invalid status", {status, levels}, {2'd1, 3'd0});
    chk(reads == 0 && lock_seen == 0, "R9 no read no lock", 64'(reads), 64'd0);
    crp = {32'h000F_0002, 32'h0000_0100};

    // R10 second start during a walk
    walk(1'b0, 1'b0, 3'd1, 32'h2001_0000, 1'b1);
    chk(status == 2'd0 && levels == 3'd4 && got_tag == 32'h2001_0000, "R10 walk unchanged",
        {got_tag, 29'd0, levels}, {32'h2001_0000, 29'd0, 3'd4});
    begin
      int extra = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (done || req_valid) extra++; end
      chk(extra == 0, "R10 ghost start ignored", 64'(extra), 64'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule